// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with APB Register File

This block gathers up to 32 active-high, level-sensitive interrupt request lines and presents them as one interrupt line to a platform-level interrupt controller. Each request line passes through a two-stage synchronizer. It then sets a sticky pending flag. A per-line mask gates the flag. The gated flags are OR-combined into a registered output.

Software reaches the block through an APB slave port with zero wait states. It reads a status word to find the lines that are both pending and unmasked. To service line n, it sets bit n of the release word and then clears that bit again. While the release bit stays at 1, pending flag n is held at 0. After the bit returns to 0, a line that is still high raises its flag again. Software updates bits of the release and mask words by read-modify-write, so both words read back exactly what was last written.

Top module: `lvl_irq_gather`

## Requirements
- R1: Reset (synchronous, active high) sets the release word to 0, the mask word to 0xFFFFFFFF (all lines masked), all pending flags to 0 and irq_out to 0.
- R2: The release word sits at byte offset 0x10. Bit n belongs to line n. A write stores all 32 bits, and a read returns the last value written.
- R3: The mask word sits at byte offset 0x14. Bit n = 1 masks line n and 0 unmasks it. A read returns the last value written.
- R4: The status word at byte offset 0x1C reads as pending AND NOT mask, with bit n standing for line n.
- R5: If line n is high before clock edge k, pending flag n is 1 after edge k+2 (two synchronizer stages, then the flag register). The flag stays at 1 after the line falls, until it is released.
- R6: While release bit n is 1, pending flag n is 0 from the edge after the write onward. Once the bit returns to 0, a line that is still high sets its flag again on the next edge.
- R7: irq_out equals the OR of the status word as it stood one clock earlier.
- R8: Writes to the status offset and to unmapped offsets change no register. Reads of unmapped offsets return 0. pready is always 1 and pslverr is always 0.
- R9: Releasing one line leaves the pending flags of all other lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | APB clock |
| rst | input | 1 | Synchronous active-high APB reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address within the block window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, combinational |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| src_in | input | 32 | Active-high level interrupt request lines |
| irq_out | output | 1 | Combined interrupt toward the platform controller |

## Verification
Register writes take effect on the edge that ends the access phase, and read data is sampled in the access phase after combinational settling. A line raised between edges sets its pending flag three edges later and irq_out one edge after that. The bench therefore samples irq_out at the falling edge after the third edge, expecting 0, and after the fourth, expecting 1. A release write clears the flag one edge after the write and drops irq_out one edge later, and the bench checks irq_out at each of those falling edges. The table-driven loop holds the release bits high long enough for stale values to drain from the synchronizer before it reads the status word.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int unsigned APB_AW = 12;
    localparam int unsigned APB_DW = 32;

    localparam logic [APB_AW-1:0] OFS_RELEASE = 12'h010;
    localparam logic [APB_AW-1:0] OFS_MASK    = 12'h014;
    localparam logic [APB_AW-1:0] OFS_STATUS  = 12'h01C;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_RELEASE,
        RSEL_MASK,
        RSEL_STATUS
    } rsel_e;

    typedef struct packed {
        logic              wr_en;
        logic              rd_en;
        rsel_e             sel;
        logic [APB_DW-1:0] wdata;
    } apb_req_t;

    function automatic rsel_e decode_offset(input logic [APB_AW-1:0] addr);
        rsel_e s;
        case (addr)
            OFS_RELEASE: s = RSEL_RELEASE;
            OFS_MASK:    s = RSEL_MASK;
            OFS_STATUS:  s = RSEL_STATUS;
            default:     s = RSEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
    import lvl_irq_pkg::*;
#(
    parameter int unsigned N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [APB_AW-1:0] paddr,
    input  logic [APB_DW-1:0] pwdata,
    input  logic [N_SRC-1:0]  status_i,
    output logic [APB_DW-1:0] prdata,
    output logic [N_SRC-1:0]  release_o,
    output logic [N_SRC-1:0]  mask_o
);
    apb_req_t          req;
    logic [N_SRC-1:0]  release_q;
    logic [N_SRC-1:0]  mask_q;

    always_comb begin
        req.wr_en = psel && penable && pwrite;
        req.rd_en = psel && !pwrite;
        req.sel   = decode_offset(paddr);
        req.wdata = pwdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            release_q <= '0;
            mask_q    <= '1;
        end else if (req.wr_en) begin
            case (req.sel)
                RSEL_RELEASE: release_q <= req.wdata[N_SRC-1:0];
                RSEL_MASK:    mask_q    <= req.wdata[N_SRC-1:0];
                default:      ;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        if (req.rd_en) begin
            case (req.sel)
                RSEL_RELEASE: prdata[N_SRC-1:0] = release_q;
                RSEL_MASK:    prdata[N_SRC-1:0] = mask_q;
                RSEL_STATUS:  prdata[N_SRC-1:0] = status_i;
                default:      prdata = '0;
            endcase
        end
    end

    assign release_o = release_q;
    assign mask_o    = mask_q;
endmodule

// File: rtl/lvl_irq_core.sv
module lvl_irq_core #(
    parameter int unsigned N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_sync,
    input  logic [N_SRC-1:0] release_i,
    input  logic [N_SRC-1:0] mask_i,
    output logic [N_SRC-1:0] pending_o,
    output logic [N_SRC-1:0] status_o,
    output logic             irq_o
);
    logic [N_SRC-1:0] pending_q;
    logic             irq_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)               pending_q[i] <= 1'b0;
            else if (release_i[i]) pending_q[i] <= 1'b0;
            else if (src_sync[i])  pending_q[i] <= 1'b1;
        end
    end

    assign status_o = pending_q & ~mask_i;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |status_o;
    end

    assign pending_o = pending_q;
    assign irq_o     = irq_q;
endmodule

// File: rtl/lvl_irq_gather.sv
module lvl_irq_gather
    import lvl_irq_pkg::*;
#(
    parameter int unsigned N_SRC       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [APB_AW-1:0] paddr,
    input  logic [APB_DW-1:0] pwdata,
    output logic [APB_DW-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [N_SRC-1:0]  src_in,
    output logic              irq_out
);
    logic [N_SRC-1:0] src_sync;
    logic [N_SRC-1:0] release_q;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] pending_q;
    logic [N_SRC-1:0] status_w;

    lvl_irq_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (src_in),
        .q_out (src_sync)
    );

    lvl_irq_regs #(.N_SRC(N_SRC)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .status_i  (status_w),
        .prdata    (prdata),
        .release_o (release_q),
        .mask_o    (mask_q)
    );

    lvl_irq_core #(.N_SRC(N_SRC)) u_core (
        .clk       (clk),
        .rst       (rst),
        .src_sync  (src_sync),
        .release_i (release_q),
        .mask_i    (mask_q),
        .pending_o (pending_q),
        .status_o  (status_w),
        .irq_o     (irq_out)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
endmodule

// File: rtl/lvl_irq_gather_chk.sv
module lvl_irq_gather_chk
    import lvl_irq_pkg::*;
#(
    parameter int unsigned N_SRC = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [APB_AW-1:0] paddr,
    input logic              irq_out,
    input logic [N_SRC-1:0]  release_q,
    input logic [N_SRC-1:0]  mask_q,
    input logic [N_SRC-1:0]  pending_q,
    input logic [N_SRC-1:0]  status_w
);
    // R1
    a_r1_reset_values: assert property (@(posedge clk)
        rst |=> (mask_q == '1 && release_q == '0 && pending_q == '0 && !irq_out));

    // R7
    a_r7_irq_tracks_status: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == ($past(status_w) != '0)));

    // R6
    a_r6_release_holds_low: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pending_q & $past(release_q)) == '0));

    // R5
    a_r5_pending_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pending_q) & ~$past(release_q) & ~pending_q) == '0));

    // R8
    a_r8_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && paddr == OFS_STATUS)
        |=> ($stable(mask_q) && $stable(release_q)));
endmodule

bind lvl_irq_gather lvl_irq_gather_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .irq_out   (irq_out),
    .release_q (release_q),
    .mask_q    (mask_q),
    .pending_q (pending_q),
    .status_w  (status_w)
);

// File: tb/lvl_irq_gather_test.sv
`timescale 1ns/1ps
module lvl_irq_gather_test;
    localparam int unsigned NV = 6;
    // each entry: {src, mask, expected status}
    localparam logic [95:0] VEC [NV] = '{
        {32'h0000_0001, 32'hFFFF_FFFE, 32'h0000_0001},
        {32'hA5A5_0F0F, 32'h0000_FFFF, 32'hA5A5_0000},
        {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF},
        {32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000},
        {32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0000},
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [31:0] src_in = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    lvl_irq_gather uut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .src_in(src_in), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic negs(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        check("R8 pready", {31'd0, pready}, 32'd1);
        check("R8 pslverr", {31'd0, pslverr}, 32'd0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 irq_out in reset", {31'd0, irq_out}, 32'd0);
        rst = 1'b0;

        // R1 reset state
        apb_rd(12'h010, rd); check("R1 release reset", rd, 32'h0);
        apb_rd(12'h014, rd); check("R1 mask reset", rd, 32'hFFFF_FFFF);
        apb_rd(12'h01C, rd); check("R1 status reset", rd, 32'h0);

        // table walk: R2 R3 R4 R7
        for (int v = 0; v < NV; v++) begin
            src_in = VEC[v][95:64];
            apb_wr(12'h014, VEC[v][63:32]);
            apb_wr(12'h010, 32'hFFFF_FFFF);
            apb_rd(12'h010, rd); check("R2 release readback", rd, 32'hFFFF_FFFF);
            apb_wr(12'h010, 32'h0);
            negs(4);
            apb_rd(12'h014, rd); check("R3 mask readback", rd, VEC[v][63:32]);
            apb_rd(12'h01C, rd); check("R4 status", rd, VEC[v][31:0]);
            check("R7 irq_out", {31'd0, irq_out}, {31'd0, VEC[v][31:0] != 32'd0});
        end

        // R5 latency and R7 registered output: mask 0, src all low, nothing pending
        apb_wr(12'h014, 32'h0);
        check("R5 idle irq", {31'd0, irq_out}, 32'd0);
        src_in = 32'h0000_0004;          // set at a falling edge
        negs(3);                         // after third rising edge: flag set, irq not yet
        check("R5 irq before flag visible", {31'd0, irq_out}, 32'd0);
        negs(1);
        check("R7 irq one edge after status", {31'd0, irq_out}, 32'd1);

        // R6: release while line held high
        apb_wr(12'h010, 32'h0000_0004);  // stored at edge W, returns at negedge after W
        check("R6 irq still high after W", {31'd0, irq_out}, 32'd1);
        negs(1);
        check("R6 irq high at W+1", {31'd0, irq_out}, 32'd1);
        negs(1);
        check("R6 irq low at W+2", {31'd0, irq_out}, 32'd0);
        apb_rd(12'h01C, rd); check("R6 status held low", rd, 32'h0);
        apb_wr(12'h010, 32'h0);          // released at edge R
        check("R6 irq low at R", {31'd0, irq_out}, 32'd0);
        negs(1);
        check("R6 irq low at R+1", {31'd0, irq_out}, 32'd0);
        negs(1);
        check("R6 irq reasserts at R+2", {31'd0, irq_out}, 32'd1);

        // R5 stickiness and R9 selective release
        src_in = 32'h0000_0088;
        negs(4);
        src_in = 32'h0;
        negs(4);
        apb_rd(12'h01C, rd); check("R5 sticky after line drops", rd, 32'h0000_008C);
        apb_wr(12'h010, 32'h0000_0008);
        apb_wr(12'h010, 32'h0);
        apb_rd(12'h01C, rd); check("R9 other lines kept", rd, 32'h0000_0084);

        // R8 ignored writes and unmapped reads
        apb_wr(12'h01C, 32'h0);
        apb_rd(12'h01C, rd); check("R8 status write ignored", rd, 32'h0000_0084);
        apb_wr(12'h000, 32'hFFFF_FFFF);
        apb_wr(12'h018, 32'hFFFF_FFFF);
        apb_rd(12'h014, rd); check("R8 mask untouched", rd, 32'h0);
        apb_rd(12'h010, rd); check("R8 release untouched", rd, 32'h0);
        apb_rd(12'h000, rd); check("R8 unmapped read 0x00", rd, 32'h0);
        apb_rd(12'h018, rd); check("R8 unmapped read 0x18", rd, 32'h0);

        // R3 masking hides pending line, R7 follows
        apb_wr(12'h014, 32'h0000_0084);
        negs(1);
        check("R3 masked irq low", {31'd0, irq_out}, 32'd0);
        apb_rd(12'h01C, rd); check("R3 masked status", rd, 32'h0);

        finish_run();
    end
endmodule